// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

Several identical processing nodes, at most six, share one external bus with an optional host. Every node carries a copy of this arbiter. Each copy watches the same wired request lines and the same host and priority lines. Every copy therefore reaches the same ownership decision on the same clock edge, with no central arbiter. A node asserts only the request line selected by its ID. It enables its address, data, select and strobe drivers only while it is the bus owner.

A host request outranks all nodes. When one arrives, the owner finishes its access and tri-states the bus for one cycle. The active-low host grant then goes low and stays low until the host withdraws its request. Between nodes, priority is fixed (lowest ID first) or rotating (the node that last won ranks lowest), chosen by a pin. A node whose core needs the bus while it is not the owner pulls the shared core-priority line low. While that line is low, every request that comes only from background DMA is withdrawn, so the core requester wins. A node with ID 0 runs alone and owns the bus except during a host tenure.

Top module: `mp_bus_arbiter`

## Requirements
- R1: `own_req_n` is low only when the node ID is in 1..NODES and the node has a pending request. An ID of 0 or above NODES never drives the line.
- R2: After reset no node enables the bus and `host_grant_n` is high.
- R3: With `rotate_mode` low, the lowest-numbered active request line wins when ownership is free.
- R4: With `rotate_mode` high, the search starts at the line just above the most recent owner and wraps around, so the last owner has the lowest rank.
- R5: The owner keeps the bus while its own request line stays low. Ownership moves only when `xfer_busy` is low and either the owner's line is high or there is no owner. The new owner's `bus_en` rises one clock edge after the decision inputs are sampled.
- R6: A non-owner with `core_req` pulls `cpa_out_n` low. While `cpa_n` is low, a node whose only request is `dma_req` holds its line high, so a core requester takes the bus from a DMA owner.
- R7: When `host_req_n` is low and `xfer_busy` is low, the next edge clears every `bus_en`, and the edge after that drives `host_grant_n` low. While `host_grant_n` is low, `bus_en` is low.
- R8: `host_grant_n` stays low while `host_req_n` is low. One edge after the host releases, the grant goes high with no owner, and node arbitration resumes on the following edge.
- R9: A node with ID 0 enables the bus from the first edge after reset and gives it up only for a host tenure.
- R10: Across nodes that share the lines, at most one `bus_en` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every node |
| rst_n | input | 1 | Synchronous active-low reset |
| node_id | input | ID_W | Node identity; 0 selects solo operation |
| rotate_mode | input | 1 | 1 selects rotating priority, 0 selects fixed priority |
| core_req | input | 1 | The local core needs the bus |
| dma_req | input | 1 | Local background DMA needs the bus |
| xfer_busy | input | 1 | Shared line: the owner's access has not finished |
| bus_req_n | input | NODES | All request lines as observed, active low; bit i is line i+1 |
| cpa_n | input | 1 | Observed wired core-priority line, active low |
| host_req_n | input | 1 | Host bus request, active low |
| own_req_n | output | 1 | Drive for this node's own request line, active low |
| cpa_out_n | output | 1 | Drive for the core-priority line, active low |
| host_grant_n | output | 1 | Host bus grant, active low, wired across nodes |
| bus_en | output | 1 | Enables the bus drivers; low means tri-state |
| master_id | output | ID_W | ID of the current node owner, 0 for none |

## Verification
A corrupted owner record shows as a second `bus_en` high, or as no owner despite pending requests, one edge after the bad decision. A stale most-recent-owner value shows only at the next handover under rotating priority, as the wrong winner. A phase error shows as a grant that appears while some node still enables the bus, or a grant that lifts while the host still requests. Each of these is visible at the ports within one or two edges of the event that exposes it.

// File: rtl/mpa_pkg.sv
// Shared types for the distributed bus arbiter.
package mpa_pkg;
    // Ownership phase that every node tracks identically.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,  // just out of reset, nobody owns the bus
        PH_NODES   = 2'd1,  // bus belongs to the nodes (or is free)
        PH_RELEASE = 2'd2,  // owner has tri-stated, grant not yet given
        PH_HOST    = 2'd3   // host owns the bus
    } arb_phase_t;
endpackage

// File: rtl/mpa_req_drive.sv
// Drives this node's own request line and the wired core-priority line.
// Assumes: node_id is static after reset; cpa_n is the wired-AND of all
// nodes' cpa_out_n, including this node's.
module mpa_req_drive #(
    parameter int NODES = 6,
    parameter int ID_W  = $clog2(NODES + 1)
) (
    input  logic [ID_W-1:0] node_id,
    input  logic            is_owner,
    input  logic            core_req,
    input  logic            dma_req,
    input  logic            cpa_n,
    output logic            own_req_n,
    output logic            cpa_out_n
);
    logic id_ok;

    // An ID maps to a request line only inside 1..NODES.
    always_comb id_ok = (node_id != '0) && (node_id <= ID_W'(NODES));

    // DMA-only demand steps aside while any core-priority claim is active.
    always_comb own_req_n = !(id_ok && (core_req || (dma_req && cpa_n)));

    // A core that is not the owner claims priority.
    always_comb cpa_out_n = !(id_ok && core_req && !is_owner);
endmodule

// File: rtl/mpa_prio_pick.sv
// Picks the winning request line, fixed or rotating priority.
// Assumes: last_id is in 1..NODES; bit i of req_vec is line i+1.
module mpa_prio_pick #(
    parameter int NODES = 6,
    parameter int ID_W  = $clog2(NODES + 1)
) (
    input  logic [NODES-1:0] req_vec,
    input  logic             rotate,
    input  logic [ID_W-1:0]  last_id,
    output logic [ID_W-1:0]  win_id,
    output logic             win_ok
);
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    // Scan the lines; rotating scan starts just above the last owner.
    always_comb begin
        win_id = '0;
        win_ok = 1'b0;
        if (rotate) begin
            for (int k = 0; k < NODES; k++) begin
                if (!win_ok && req_vec[IDX_W'((int'(last_id) + k) % NODES)]) begin
                    win_ok = 1'b1;
                    win_id = ID_W'(((int'(last_id) + k) % NODES) + 1);
                end
            end
        end else begin
            for (int k = NODES - 1; k >= 0; k--) begin
                if (req_vec[IDX_W'(k)]) begin
                    win_ok = 1'b1;
                    win_id = ID_W'(k + 1);
                end
            end
        end
    end
endmodule

// File: rtl/mpa_phase_fsm.sv
// Ownership state kept identically by every node: phase, owner, last owner.
// Assumes: all inputs are the shared lines seen by every node on one edge.
module mpa_phase_fsm
    import mpa_pkg::*;
#(
    parameter int NODES = 6,
    parameter int ID_W  = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             xfer_busy,
    input  logic [NODES-1:0] req_vec,
    input  logic [ID_W-1:0]  win_id,
    input  logic             win_ok,
    output arb_phase_t       phase,
    output logic [ID_W-1:0]  owner_id,
    output logic [ID_W-1:0]  last_id
);
    localparam int IDX_W = (NODES > 1) ? $clog2(NODES) : 1;

    arb_phase_t      phase_q;
    logic [ID_W-1:0] owner_q;
    logic [ID_W-1:0] last_q;
    logic            owner_line;
    logic            may_move;

    // Is the current owner still asserting its own request line?
    always_comb owner_line = (owner_q != '0) && req_vec[IDX_W'(int'(owner_q) - 1)];

    // Ownership can change only between accesses and when not held.
    always_comb may_move = !xfer_busy && !owner_line && win_ok;

    // Phase, owner and most-recent-owner register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            owner_q <= '0;
            last_q  <= ID_W'(NODES);
        end else begin
            case (phase_q)
                PH_IDLE:  phase_q <= PH_NODES;
                PH_NODES: begin
                    if (host_req && !xfer_busy) begin
                        phase_q <= PH_RELEASE;
                        owner_q <= '0;
                    end else if (may_move) begin
                        owner_q <= win_id;
                        last_q  <= win_id;
                    end
                end
                PH_RELEASE: phase_q <= host_req ? PH_HOST : PH_NODES;
                PH_HOST:    if (!host_req) phase_q <= PH_NODES;
                default:    phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase    = phase_q;
    assign owner_id = owner_q;
    assign last_id  = last_q;
endmodule

// File: rtl/mp_bus_arbiter.sv
// Per-node arbiter for a bus shared by up to NODES processors and a host.
// Every node computes the same decision from the shared lines; this node
// enables its bus drivers only while it owns the bus.
// Assumes: rotate_mode and host_req_n are seen by all nodes on one edge;
// bus_req_n lines with no node attached are pulled high.
module mp_bus_arbiter
    import mpa_pkg::*;
#(
    parameter int NODES = 6,
    parameter int ID_W  = $clog2(NODES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ID_W-1:0]  node_id,
    input  logic             rotate_mode,
    input  logic             core_req,
    input  logic             dma_req,
    input  logic             xfer_busy,
    input  logic [NODES-1:0] bus_req_n,
    input  logic             cpa_n,
    input  logic             host_req_n,
    output logic             own_req_n,
    output logic             cpa_out_n,
    output logic             host_grant_n,
    output logic             bus_en,
    output logic [ID_W-1:0]  master_id
);
    arb_phase_t      phase;
    logic [ID_W-1:0] owner_id;
    logic [ID_W-1:0] last_id;
    logic [ID_W-1:0] win_id;
    logic            win_ok;
    logic [NODES-1:0] req_vec;
    logic            solo;

    // Active-high view of the request lines.
    always_comb req_vec = ~bus_req_n;

    // ID 0 means a single node that never arbitrates.
    always_comb solo = (node_id == '0);

    mpa_req_drive #(.NODES(NODES), .ID_W(ID_W)) drive_i (
        .node_id   (node_id),
        .is_owner  (bus_en),
        .core_req  (core_req),
        .dma_req   (dma_req),
        .cpa_n     (cpa_n),
        .own_req_n (own_req_n),
        .cpa_out_n (cpa_out_n)
    );

    mpa_prio_pick #(.NODES(NODES), .ID_W(ID_W)) pick_i (
        .req_vec (req_vec),
        .rotate  (rotate_mode),
        .last_id (last_id),
        .win_id  (win_id),
        .win_ok  (win_ok)
    );

    mpa_phase_fsm #(.NODES(NODES), .ID_W(ID_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_req  (!host_req_n),
        .xfer_busy (xfer_busy),
        .req_vec   (req_vec),
        .win_id    (win_id),
        .win_ok    (win_ok),
        .phase     (phase),
        .owner_id  (owner_id),
        .last_id   (last_id)
    );

    // Drive the bus only while the nodes hold it and this node owns it.
    always_comb bus_en = (phase == PH_NODES) && (solo || (owner_id == node_id));

    // Grant is identical on every node, so the wired-AND is consistent.
    always_comb host_grant_n = (phase != PH_HOST);

    // Owner ID seen by this node (0 while nobody or the host owns).
    always_comb master_id = (phase == PH_NODES) ? owner_id : '0;
endmodule

// File: rtl/mpa_check.sv
// Property checker for one arbiter node; attached through bind below.
module mpa_check #(
    parameter int NODES = 6,
    parameter int ID_W  = $clog2(NODES + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ID_W-1:0] node_id,
    input logic            xfer_busy,
    input logic            host_req_n,
    input logic            own_req_n,
    input logic            host_grant_n,
    input logic            bus_en
);
    // R7: the grant falls only after a cycle with the bus tri-stated.
    assert_grant_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_grant_n) |-> !$past(bus_en));

    // R7: no bus drive while the host holds the grant.
    assert_quiet_in_host_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_grant_n |-> !bus_en);

    // R8: the grant persists while the host still requests.
    assert_grant_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_grant_n && !host_req_n) |=> !host_grant_n);

    // R5: an owner is never displaced mid-access.
    assert_hold_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && xfer_busy) |=> bus_en);

    // R5: an arbitrating node gains the bus only after requesting it.
    assert_win_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_en) && node_id != '0) |-> !$past(own_req_n));

    // R1: an ID outside 1..NODES never drives a request line.
    assert_line_only_valid_id_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (node_id == '0 || node_id > ID_W'(NODES)) |-> own_req_n);
endmodule

bind mp_bus_arbiter mpa_check #(.NODES(NODES), .ID_W(ID_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .node_id      (node_id),
    .xfer_busy    (xfer_busy),
    .host_req_n   (host_req_n),
    .own_req_n    (own_req_n),
    .host_grant_n (host_grant_n),
    .bus_en       (bus_en)
);

// File: tb/mp_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
// Six nodes on shared wired lines plus one solo node; scoreboard bench.
module mp_bus_arbiter_tb_top;
    localparam int N    = 6;
    localparam int ID_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic           rotate = 1'b0;
    logic           busy = 1'b0;
    logic           host_n = 1'b1;
    logic [N-1:0]   core = '0;
    logic [N-1:0]   dma = '0;
    logic [N-1:0]   req_n, cpa_o, gnt_o, en;
    logic [ID_W-1:0] mid [N];
    logic           cpa_line, grant_line;

    assign cpa_line   = &cpa_o;
    assign grant_line = &gnt_o;

    for (genvar g = 0; g < N; g++) begin : g_node
        mp_bus_arbiter #(.NODES(N)) node_i (
            .clk(clk), .rst_n(rst_n), .node_id(ID_W'(g + 1)),
            .rotate_mode(rotate), .core_req(core[g]), .dma_req(dma[g]),
            .xfer_busy(busy), .bus_req_n(req_n), .cpa_n(cpa_line),
            .host_req_n(host_n), .own_req_n(req_n[g]), .cpa_out_n(cpa_o[g]),
            .host_grant_n(gnt_o[g]), .bus_en(en[g]), .master_id(mid[g])
        );
    end

    // Solo node (ID 0) on its own host line.
    logic s_host_n = 1'b1;
    logic s_req_n, s_cpa_n, s_gnt_n, s_en;
    logic [ID_W-1:0] s_mid;
    mp_bus_arbiter #(.NODES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .node_id('0), .rotate_mode(1'b0),
        .core_req(1'b0), .dma_req(1'b1), .xfer_busy(1'b0),
        .bus_req_n({N{1'b1}}), .cpa_n(1'b1), .host_req_n(s_host_n),
        .own_req_n(s_req_n), .cpa_out_n(s_cpa_n), .host_grant_n(s_gnt_n),
        .bus_en(s_en), .master_id(s_mid)
    );

    int checks = 0;
    int fails  = 0;
    int overlaps = 0;

    typedef struct {
        logic [N-1:0] en;
        logic         gnt_n;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // Monitor: pop one expectation per falling edge and compare.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (en !== e.en || grant_line !== e.gnt_n) begin
                fails++;
                $display("FAIL %s: en=%b gnt_n=%b expected en=%b gnt_n=%b",
                         e.tag, en, grant_line, e.en, e.gnt_n);
            end
        end
        if (rst_n && $countones(en) > 1) overlaps++;
    end

    // Driver: wait one edge, queue the expected state, return at the next falling edge.
    task automatic cyc(input logic [N-1:0] e_en, input logic e_gnt, input string tag);
        exp_t e;
        @(posedge clk);
        e.en = e_en; e.gnt_n = e_gnt; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One-hot enable vector for node n (1-based).
    function automatic logic [N-1:0] oh(input int n);
        return (n == 0) ? '0 : (N'(1) << (n - 1));
    endfunction

    initial begin : wd
        #(5.0 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc('0, 1'b1, "R2 reset: no owner, no grant");
        chk(s_en === 1'b1, "R9 solo owns after reset", int'(s_en), 1);
        chk(s_req_n === 1'b1, "R1 ID0 never drives a line", int'(s_req_n), 1);

        // Fixed priority.
        dma[2] = 1; dma[4] = 1;
        cyc(oh(3), 1'b1, "R3 fixed picks 3 over 5");
        dma[2] = 0; dma[1] = 1;
        cyc(oh(2), 1'b1, "R3 fixed picks 2 over 5");

        // Busy holds ownership.
        busy = 1; dma[1] = 0;
        cyc(oh(2), 1'b1, "R5 busy keeps owner 2");
        busy = 0;
        cyc(oh(5), 1'b1, "R5 handover to 5 after access");

        // Rotating priority.
        rotate = 1; dma[4] = 0; dma[0] = 1; dma[1] = 1; dma[5] = 1;
        cyc(oh(6), 1'b1, "R4 rotate after 5 picks 6");
        dma[5] = 0;
        cyc(oh(1), 1'b1, "R4 rotate wraps to 1");
        dma[0] = 0;
        cyc(oh(2), 1'b1, "R4 rotate picks 2");
        dma[1] = 0; dma[0] = 1; dma[3] = 1;
        cyc(oh(4), 1'b1, "R4 rotate after 2 picks 4 over 1");

        // Owner holds against a higher fixed priority.
        rotate = 0;
        cyc(oh(4), 1'b1, "R5 owner 4 holds while requesting");

        // Core priority claim.
        core[5] = 1;
        cyc(oh(6), 1'b1, "R6 core on 6 preempts DMA owner 4");
        cyc(oh(6), 1'b1, "R5 core owner 6 holds");

        // Host tenure.
        host_n = 0; busy = 1;
        cyc(oh(6), 1'b1, "R7 host waits for access end");
        busy = 0;
        cyc('0, 1'b1, "R7 bus released before grant");
        cyc('0, 1'b0, "R7 grant low");
        cyc('0, 1'b0, "R8 grant held");
        cyc('0, 1'b0, "R8 grant held 2");
        host_n = 1;
        cyc('0, 1'b1, "R8 grant lifted, no owner");
        cyc(oh(6), 1'b1, "R6 core claim wins after host");

        // Solo node host tenure.
        s_host_n = 0;
        @(posedge clk); @(negedge clk);
        chk(s_en === 1'b0 && s_gnt_n === 1'b1, "R9 solo releases for host", int'(s_en), 0);
        @(posedge clk); @(negedge clk);
        chk(s_gnt_n === 1'b0, "R9 solo grants host", int'(s_gnt_n), 0);
        s_host_n = 1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        chk(s_en === 1'b1, "R9 solo resumes ownership", int'(s_en), 1);

        chk(overlaps == 0, "R10 at most one owner", overlaps, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule